// File: doc/BRIEF.md
# Microcontroller power-mode controller

This block owns the power-control special function register of an 8-bit microcontroller and turns its contents into clock and power gating for the rest of the chip. It produces four control outputs: a CPU clock enable, a peripheral clock enable, an oscillator-run signal and a peripheral-disable signal. Software can request a halt of the CPU only, with peripherals and interrupt logic still clocked. It can also request a full stop, in which the oscillator halts and the clocked peripherals are disabled.

The halt state of the CPU ends when any enabled interrupt is pending. The full-stop state ends only through a reset. The block also qualifies resets. An external reset pin must be held through two consecutive machine cycles before it is accepted. An internal reset request is accepted at once. After any accepted reset, the core is released three machine cycles after the reset source goes away. A one-clock machine-cycle strobe paces all of this counting.

The six upper register bits are plain storage, handed to other blocks on a dedicated output.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After rst_ni, the register reads 0x00, cpu_clk_en_o, per_clk_en_o and osc_run_o are 1, and per_dis_o and core_rst_o are 0.
- R2: A write at SFR address 0x87 while the CPU runs stores the byte, and a read at 0x87 returns it. Bits 7:2 appear on ctl_bits_o. A read at any other address returns 0x00, and a write to any other address leaves the register unchanged.
- R3: A write with bit 0 set and bit 1 clear enters the halt state. From the next clock, cpu_clk_en_o is 0 while per_clk_en_o and osc_run_o stay 1, and bit 0 reads back 1.
- R4: In the halt state, a cycle with irq_pend_i high clears bit 0 and sets cpu_clk_en_o to 1 from the next clock. In the running state, irq_pend_i has no effect.
- R5: A write with bit 1 set enters the stop state. From the next clock, cpu_clk_en_o, per_clk_en_o and osc_run_o are 0 and per_dis_o is 1.
- R6: If bits 1 and 0 are both written as 1, the stop state is taken and bit 0 reads back 0.
- R7: In the stop state, irq_pend_i is ignored: the outputs and the register keep their values.
- R8: An external reset is accepted only on the second consecutive machine-cycle strobe with ext_rst_i high. A low level between strobes restarts the count. In the stop state, osc_run_o follows ext_rst_i high without waiting for a clock.
- R9: An accepted reset sets core_rst_o to 1 and clears the register. The core is released on the third machine-cycle strobe after the reset source is gone, counting from that point.
- R10: int_rst_req_i high for one clock sets core_rst_o to 1 from the next clock, from any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| sfr_addr_i | input | 8 | SFR bus address |
| sfr_wr_i | input | 1 | SFR write strobe |
| sfr_wdata_i | input | 8 | SFR write data |
| sfr_rdata_o | output | 8 | SFR read data (0 when not addressed) |
| irq_pend_i | input | 1 | Any enabled interrupt pending |
| ext_rst_i | input | 1 | External reset pin, active high |
| int_rst_req_i | input | 1 | Internal reset request |
| mcyc_stb_i | input | 1 | One-clock machine-cycle strobe |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| per_clk_en_o | output | 1 | Peripheral clock enable |
| osc_run_o | output | 1 | Oscillator run |
| per_dis_o | output | 1 | Disable for the peripherals stopped in the stop state |
| core_rst_o | output | 1 | Reset to the core |
| ctl_bits_o | output | 6 | Upper six register bits |

## Verification
The bench sweeps the length of the external reset pulse against several gaps between strobes. A controller that counted clocks instead of strobes, or that accepted a single strobe, would reset on a one-cycle glitch. A controller that did not restart the count on a low level would accept two separated single-strobe pulses. The release count is checked at its last strobe, so an off-by-one release would free the core a strobe early or late. The bench also writes both mode bits together and sends interrupts in every state. A controller with the wrong priority would halt only the CPU. A controller that honoured interrupts in the stop state would restart the clocks without a reset.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_IDLE  = 2'd1,
    ST_PDOWN = 2'd2,
    ST_RESET = 2'd3
  } pwr_state_e;

  localparam int IDLE_BIT = 0;
  localparam int PD_BIT   = 1;
endpackage

// File: rtl/pwr_sfr_reg.sv
module pwr_sfr_reg #(
  parameter int          DW   = 8,
  parameter int          AW   = 8,
  parameter logic [7:0]  ADDR = 8'h87
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          wr_ok_i,
  input  logic          clr_idle_i,
  input  logic          clr_all_i,
  output logic          wr_hit_o,
  output logic [DW-1:0] q_o,
  output logic [DW-1:0] rdata_o
);
  import pwr_pkg::*;

  logic hit;
  logic [DW-1:0] q;

  assign hit      = (addr_i == AW'(ADDR));
  assign wr_hit_o = wr_i & hit & wr_ok_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q <= '0;
    end else if (clr_all_i) begin
      q <= '0;
    end else if (wr_hit_o) begin
      q <= wdata_i;
      // stop request wins over halt request
      if (wdata_i[PD_BIT]) q[IDLE_BIT] <= 1'b0;
    end else if (clr_idle_i) begin
      q[IDLE_BIT] <= 1'b0;
    end
  end

  assign q_o     = q;
  assign rdata_o = hit ? q : '0;
endmodule

// File: rtl/pwr_rst_seq.sv
module pwr_rst_seq #(
  parameter int EXT_QUAL = 2,
  parameter int RESTART  = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mcyc_en_i,
  input  logic ext_rst_i,
  input  logic int_req_i,
  input  logic in_rst_i,
  output logic ext_qual_o,
  output logic release_o
);
  localparam int EW = $clog2(EXT_QUAL + 1);
  localparam int RW = $clog2(RESTART + 1);

  logic [EW-1:0] ext_cnt;
  logic [RW-1:0] rel_cnt;
  logic          ext_last, rel_last;

  assign ext_last = (ext_cnt == EW'(EXT_QUAL - 1));
  assign rel_last = (rel_cnt == RW'(RESTART - 1));

  // consecutive strobes with the pin high; a low level restarts the count
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       ext_cnt <= '0;
    else if (!ext_rst_i)               ext_cnt <= '0;
    else if (mcyc_en_i && !ext_last)   ext_cnt <= ext_cnt + 1'b1;
  end

  assign ext_qual_o = mcyc_en_i & ext_rst_i & ext_last;

  // release count starts once every reset source is gone
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   rel_cnt <= '0;
    else if (!in_rst_i || ext_rst_i || int_req_i)  rel_cnt <= '0;
    else if (mcyc_en_i && !rel_last)               rel_cnt <= rel_cnt + 1'b1;
  end

  assign release_o = in_rst_i & ~ext_rst_i & ~int_req_i & mcyc_en_i & rel_last;
endmodule

// File: rtl/pwr_fsm.sv
module pwr_fsm (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_hit_i,
  input  logic                wr_pd_i,
  input  logic                wr_idle_i,
  input  logic                irq_i,
  input  logic                rst_take_i,
  input  logic                release_i,
  output pwr_pkg::pwr_state_e state_o
);
  import pwr_pkg::*;

  pwr_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (rst_take_i) begin
      state_d = ST_RESET;
    end else begin
      unique case (state_q)
        ST_RUN:   if (wr_hit_i && wr_pd_i)        state_d = ST_PDOWN;
                  else if (wr_hit_i && wr_idle_i) state_d = ST_IDLE;
        ST_IDLE:  if (irq_i)                      state_d = ST_RUN;
        ST_PDOWN: state_d = ST_PDOWN;
        ST_RESET: if (release_i)                  state_d = ST_RUN;
        default:  state_d = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_RUN;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl #(
  parameter int         DW       = 8,
  parameter int         AW       = 8,
  parameter logic [7:0] REG_ADDR = 8'h87,
  parameter int         EXT_QUAL = 2,
  parameter int         RESTART  = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] sfr_addr_i,
  input  logic          sfr_wr_i,
  input  logic [DW-1:0] sfr_wdata_i,
  output logic [DW-1:0] sfr_rdata_o,
  input  logic          irq_pend_i,
  input  logic          ext_rst_i,
  input  logic          int_rst_req_i,
  input  logic          mcyc_stb_i,
  output logic          cpu_clk_en_o,
  output logic          per_clk_en_o,
  output logic          osc_run_o,
  output logic          per_dis_o,
  output logic          core_rst_o,
  output logic [DW-3:0] ctl_bits_o
);
  import pwr_pkg::*;

  pwr_state_e    state_q;
  logic          wr_hit, ext_qual, rel, rst_take;
  logic [DW-1:0] reg_q;
  logic          in_pd, in_rst;

  assign in_pd    = (state_q == ST_PDOWN);
  assign in_rst   = (state_q == ST_RESET);
  assign rst_take = ext_qual | int_rst_req_i;

  pwr_sfr_reg #(.DW(DW), .AW(AW), .ADDR(REG_ADDR)) u_reg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (sfr_addr_i),
    .wr_i       (sfr_wr_i),
    .wdata_i    (sfr_wdata_i),
    .wr_ok_i    (state_q == ST_RUN),
    .clr_idle_i ((state_q == ST_IDLE) & irq_pend_i),
    .clr_all_i  (rst_take | in_rst),
    .wr_hit_o   (wr_hit),
    .q_o        (reg_q),
    .rdata_o    (sfr_rdata_o)
  );

  pwr_rst_seq #(.EXT_QUAL(EXT_QUAL), .RESTART(RESTART)) u_rst (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mcyc_en_i  (mcyc_stb_i & osc_run_o),
    .ext_rst_i  (ext_rst_i),
    .int_req_i  (int_rst_req_i),
    .in_rst_i   (in_rst),
    .ext_qual_o (ext_qual),
    .release_o  (rel)
  );

  pwr_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_hit_i   (wr_hit),
    .wr_pd_i    (sfr_wdata_i[PD_BIT]),
    .wr_idle_i  (sfr_wdata_i[IDLE_BIT]),
    .irq_i      (irq_pend_i),
    .rst_take_i (rst_take),
    .release_i  (rel),
    .state_o    (state_q)
  );

  assign cpu_clk_en_o = (state_q == ST_RUN) | in_rst;
  assign per_clk_en_o = ~in_pd;
  // pin wakes the oscillator without a clock so qualification can run
  assign osc_run_o    = ~in_pd | ext_rst_i;
  assign per_dis_o    = in_pd;
  assign core_rst_o   = in_rst;
  assign ctl_bits_o   = reg_q[DW-1:2];
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk (
  input logic                clk_i,
  input logic                rst_ni,
  input pwr_pkg::pwr_state_e state_i,
  input logic                wr_hit_i,
  input logic [7:0]          wdata_i,
  input logic                irq_pend_i,
  input logic                ext_rst_i,
  input logic                int_rst_req_i,
  input logic                mcyc_stb_i,
  input logic                cpu_clk_en_o,
  input logic                per_clk_en_o,
  input logic                per_dis_o,
  input logic                core_rst_o
);
  import pwr_pkg::*;

  // R3
  idle_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_hit_i && wdata_i[0] && !wdata_i[1] && !ext_rst_i && !int_rst_req_i)
    |=> (!cpu_clk_en_o && per_clk_en_o));

  // R5
  pd_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_hit_i && wdata_i[1] && !ext_rst_i && !int_rst_req_i)
    |=> (per_dis_o && !cpu_clk_en_o && !per_clk_en_o));

  // R4
  idle_wake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_IDLE && irq_pend_i && !ext_rst_i && !int_rst_req_i)
    |=> cpu_clk_en_o);

  // R7
  pd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_PDOWN && !ext_rst_i && !int_rst_req_i)
    |=> (state_i == ST_PDOWN));

  // R10
  int_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_rst_req_i |=> core_rst_o);

  // R9
  rst_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(core_rst_o) |-> ($past(mcyc_stb_i) && !$past(ext_rst_i)));
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .state_i       (state_q),
  .wr_hit_i      (wr_hit),
  .wdata_i       (sfr_wdata_i),
  .irq_pend_i    (irq_pend_i),
  .ext_rst_i     (ext_rst_i),
  .int_rst_req_i (int_rst_req_i),
  .mcyc_stb_i    (mcyc_stb_i),
  .cpu_clk_en_o  (cpu_clk_en_o),
  .per_clk_en_o  (per_clk_en_o),
  .per_dis_o     (per_dis_o),
  .core_rst_o    (core_rst_o)
);

// File: tb/sim_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module sim_pwr_mode_ctrl;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] sfr_addr_i = 8'h00;
  logic       sfr_wr_i = 1'b0;
  logic [7:0] sfr_wdata_i = 8'h00;
  logic [7:0] sfr_rdata_o;
  logic       irq_pend_i = 1'b0;
  logic       ext_rst_i = 1'b0;
  logic       int_rst_req_i = 1'b0;
  logic       mcyc_stb_i = 1'b0;
  logic       cpu_clk_en_o, per_clk_en_o, osc_run_o, per_dis_o, core_rst_o;
  logic [5:0] ctl_bits_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  pwr_mode_ctrl u0 (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i); #1;
  endtask

  task automatic strobe();
    mcyc_stb_i = 1'b1; tick(); mcyc_stb_i = 1'b0;
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    sfr_addr_i = a; sfr_wdata_i = d; sfr_wr_i = 1'b1;
    tick(); sfr_wr_i = 1'b0; sfr_addr_i = 8'h87;
  endtask

  task automatic rd(string req, logic [7:0] a, logic [7:0] exp);
    sfr_addr_i = a; #0.5;
    chk(req, sfr_rdata_o, exp);
    sfr_addr_i = 8'h87;
  endtask

  // outputs as {cpu, per, osc, pdis, rst}
  function automatic logic [4:0] outs();
    return {cpu_clk_en_o, per_clk_en_o, osc_run_o, per_dis_o, core_rst_o};
  endfunction

  task automatic release_seq(string req);
    strobe(); tick(); strobe();
    chk(req, core_rst_o, 1'b1);
    tick(); tick();
    strobe();
    chk(req, outs(), 5'b11100);
  endtask

  initial begin
    repeat (3) tick();
    rst_ni = 1'b1; tick();
    // R1
    chk("R1", outs(), 5'b11100);
    rd("R1", 8'h87, 8'h00);

    // R2 sweep of the storage bits
    for (int v = 0; v < 64; v++) begin
      wr(8'h87, {v[5:0], 2'b00});
      rd("R2", 8'h87, {v[5:0], 2'b00});
      chk("R2 ctl", ctl_bits_o, v[5:0]);
    end
    wr(8'h86, 8'hFF);
    rd("R2 other addr", 8'h86, 8'h00);
    rd("R2 no alias", 8'h87, 8'hFC);
    wr(8'h87, 8'h00);

    // R4 irq while running
    irq_pend_i = 1'b1; tick(); irq_pend_i = 1'b0;
    chk("R4 run irq", outs(), 5'b11100);
    rd("R4 run irq", 8'h87, 8'h00);

    // R3 halt
    wr(8'h87, 8'h41);
    chk("R3", outs(), 5'b01100);
    rd("R3", 8'h87, 8'h41);
    tick(); tick();
    chk("R3 held", outs(), 5'b01100);

    // R4 wake
    irq_pend_i = 1'b1; tick(); irq_pend_i = 1'b0;
    chk("R4", outs(), 5'b11100);
    rd("R4", 8'h87, 8'h40);

    // R5 stop
    wr(8'h87, 8'h82);
    chk("R5", outs(), 5'b00010);
    rd("R5", 8'h87, 8'h82);

    // R7 interrupts and strobes ignored in stop
    irq_pend_i = 1'b1; tick(); strobe(); irq_pend_i = 1'b0;
    chk("R7", outs(), 5'b00010);
    rd("R7", 8'h87, 8'h82);

    // R8 pin wakes oscillator at once
    ext_rst_i = 1'b1; #0.5;
    chk("R8 osc", osc_run_o, 1'b1);
    strobe();
    chk("R8 one strobe", core_rst_o, 1'b0);
    strobe();
    chk("R8 two strobes", core_rst_o, 1'b1);
    rd("R9 cleared", 8'h87, 8'h00);
    ext_rst_i = 1'b0;
    release_seq("R9 release");

    // R6 both bits
    wr(8'h87, 8'h03);
    chk("R6", outs(), 5'b00010);
    rd("R6", 8'h87, 8'h02);

    // R10 internal reset from stop
    int_rst_req_i = 1'b1; tick(); int_rst_req_i = 1'b0;
    chk("R10", core_rst_o, 1'b1);
    rd("R10 cleared", 8'h87, 8'h00);
    release_seq("R9 int release");

    // R10 from halt
    wr(8'h87, 8'h01);
    int_rst_req_i = 1'b1; tick(); int_rst_req_i = 1'b0;
    chk("R10 halt", core_rst_o, 1'b1);
    release_seq("R9 int release halt");

    // R8 sweep: pulse length in strobes against gap
    for (int g = 0; g < 3; g++) begin
      for (int n = 0; n < 4; n++) begin
        wr(8'h87, 8'hA4);
        ext_rst_i = 1'b1;
        for (int i = 0; i < n; i++) begin
          repeat (g) tick();
          strobe();
        end
        repeat (g) tick();
        chk("R8 sweep", core_rst_o, (n >= 2) ? 1'b1 : 1'b0);
        ext_rst_i = 1'b0;
        if (n >= 2) release_seq("R9 sweep");
        else rd("R8 sweep kept", 8'h87, 8'hA4);
      end
    end

    // R8 non-consecutive pulses
    wr(8'h87, 8'h24);
    ext_rst_i = 1'b1; strobe(); ext_rst_i = 1'b0; tick();
    ext_rst_i = 1'b1; strobe(); ext_rst_i = 1'b0; tick();
    chk("R8 broken", core_rst_o, 1'b0);
    rd("R8 broken", 8'h87, 8'h24);

    // R9 pin held long keeps reset, count starts at release
    ext_rst_i = 1'b1; strobe(); strobe();
    repeat (4) strobe();
    chk("R9 held", core_rst_o, 1'b1);
    ext_rst_i = 1'b0;
    release_seq("R9 held release");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule